// File: doc/BRIEF.md
# Redundant Bit-Stream Exact Multiplier

This block multiplies two small unsigned operands without a binary adder array. Every AND of an operand-A bit with an operand-B bit is written into a unary stream as many times as its binary weight. The base stream is therefore a run of single bits whose count of ones is exactly the product. The bits are grouped by weight, from weight 1 up to the largest weight.

For robustness each base bit is sent several times in a row. A short fixed pad follows. The whole stream leaves the block serially, one bit per clock. Three copies of a ones counter read the same stream. Each copy turns its count back into a binary product by dividing by the repetition factor, and a bitwise two-of-three vote gives the final result. The margin that the pad provides lets the decoder tolerate several flipped stream bits.

Two injection inputs are provided for fault studies. One flips the stream bit of the current cycle. The other upsets individual counter copies.

Top module: `bsm_mult`

## Requirements
- R1: During and after reset, `done`, `stream_valid` and `stream_out` are 0 and `product` is 0.
- R2: A `start` accepted while idle produces exactly 399 consecutive cycles with `stream_valid` high. `done` follows as a single-cycle pulse two cycles after the last valid cycle, with `stream_valid` low.
- R3: With no injected faults, the number of ones on `stream_out` during a run equals 8·A·B + 4.
- R4: The stream layout is fixed. Bits 0..391 are 49 base bits, each repeated 8 times in a row. The first base bit is A[0]&B[0], the weight-1 term. The last 7 bits are 1,1,1,1,0,0,0 in that order.
- R5: With no injected faults, `product` equals A·B for all 64 operand pairs. It holds its value between `done` pulses.
- R6: `product` = floor(ones/8). A net change of −4..+3 in the stream's ones count, made through `flip_in`, still yields the correct product. A change of −5 or +4 changes it by one.
- R7: `start` is ignored while a run is in progress. The operands captured at the accepted start are used for the whole run.
- R8: Each cycle in which `upset_in[k]` is high during a run adds 8 to counter copy k. An upset confined to one copy is outvoted. The same upsets on two copies move the product by one per upset cycle.
- R9: A counter copy whose count divided by 8 exceeds 63 reports 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with the present operands (idle only) |
| op_a | input | 3 | Operand A, unsigned |
| op_b | input | 3 | Operand B, unsigned |
| flip_in | input | 1 | Inverts the stream bit of this cycle |
| upset_in | input | 3 | Per-copy counter upset, adds 8 to that copy this cycle |
| stream_out | output | 1 | Serial redundant stream, after fault injection |
| stream_valid | output | 1 | High for each stream bit |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 6 | Voted decoded product |

## Verification
The following are checked on every cycle:
- The stream position stays inside its length while valid.
- `done` is a single-cycle pulse that follows the end of the stream.
- Operands do not move during a run.
- Within a fault-free repetition group, consecutive stream bits are equal.
- When the first two counter copies agree, the voted product matches them.
- The product holds between pulses.

Other properties rest on the bench's scenarios alone:
- The exact ones count, the pad at the tail and the position of the weight-1 term.
- The exact product for every operand pair.
- The error margin at its limits.
- Masking of an upset to a single copy against the failure when two copies are upset.
- Saturation.

// File: rtl/bsm_pkg.sv
// Shared types for the bit-stream multiplier.
// Assumes nothing beyond standard SystemVerilog.
package bsm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } bsm_phase_t;
endpackage

// File: rtl/bsm_stream_gen.sv
// Combinational stream source: for position pos, returns the redundant
// stream bit for operands a and b. Base bits are laid out by ascending
// weight, each AND term copied 2^(i+j) times. Every base bit is repeated
// REP times, then PAD_PAT follows, MSB first.
// Assumes pos < BASE_LEN*REP + PAD_LEN.
module bsm_stream_gen #(
    parameter int                 OP_W    = 3,
    parameter int                 REP     = 8,
    parameter int                 PAD_LEN = 7,
    parameter logic [PAD_LEN-1:0] PAD_PAT = 7'b1111000,
    parameter int                 POS_W   = 9
) (
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    input  logic [POS_W-1:0] pos,
    output logic             bit_o
);
    localparam int BASE_LEN = ((1 << OP_W) - 1) * ((1 << OP_W) - 1);
    localparam int REP_LEN  = BASE_LEN * REP;

    // Weight-expanded unary image of a*b.
    function automatic logic [BASE_LEN-1:0] expand(input logic [OP_W-1:0] fa,
                                                   input logic [OP_W-1:0] fb);
        logic [BASE_LEN-1:0] v;
        int off;
        int i;
        v   = '0;
        off = 0;
        for (int k = 0; k < 2 * OP_W - 1; k++) begin
            for (int j = 0; j < OP_W; j++) begin
                i = k - j;
                if (i >= 0 && i < OP_W) begin
                    for (int c = 0; c < (1 << k); c++) begin
                        v[off] = fa[j] & fb[i];
                        off++;
                    end
                end
            end
        end
        return v;
    endfunction

    logic [BASE_LEN-1:0] base;
    int unsigned         p;

    // Select the replicated base bit or the pad bit for this position.
    always_comb begin
        base = expand(a, b);
        p    = 32'(pos);
        if (p < REP_LEN) bit_o = base[p / REP];
        else             bit_o = PAD_PAT[PAD_LEN - 1 - int'(p - REP_LEN)];
    end
endmodule

// File: rtl/bsm_ones_counter.sv
// One copy of the decoding counter. It accumulates stream ones and injected
// upsets (each upset adds REP). It reports count/REP saturated to Q_W bits.
// Assumes REP is a power of two and CNT_W holds the largest possible count.
module bsm_ones_counter #(
    parameter int CNT_W = 12,
    parameter int Q_W   = 6,
    parameter int REP   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           en,
    input  logic           bit_in,
    input  logic           upset,
    output logic [Q_W-1:0] quot
);
    localparam int SH   = $clog2(REP);
    localparam int MAXQ = (1 << Q_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full;

    // Count ones and upsets over one run; clear on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + CNT_W'(bit_in) + (upset ? CNT_W'(REP) : '0);
    end

    // Divide by the repetition factor and saturate.
    always_comb begin
        full = cnt_q >> SH;
        quot = (full > CNT_W'(MAXQ)) ? Q_W'(MAXQ) : full[Q_W-1:0];
    end
endmodule

// File: rtl/bsm_voter.sv
// Bitwise two-of-three majority over W-bit words. Purely combinational.
module bsm_voter #(
    parameter int W = 6
) (
    input  logic [W-1:0] v0,
    input  logic [W-1:0] v1,
    input  logic [W-1:0] v2,
    output logic [W-1:0] v
);
    // Majority per bit.
    always_comb v = (v0 & v1) | (v0 & v2) | (v1 & v2);
endmodule

// File: rtl/bsm_mult.sv
// Redundant bit-stream exact multiplier, top level.
// It accepts start only when idle, streams STREAM_LEN bits (one per clock)
// into three counter copies, then votes and publishes the product with a
// done pulse. Fault inputs: flip_in XORs the current stream bit, and
// upset_in[k] adds REP to counter copy k.
// Assumes REP is a power of two.
module bsm_mult #(
    parameter int                 OP_W    = 3,
    parameter int                 REP     = 8,
    parameter int                 PAD_LEN = 7,
    parameter logic [PAD_LEN-1:0] PAD_PAT = 7'b1111000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              flip_in,
    input  logic [2:0]        upset_in,
    output logic              stream_out,
    output logic              stream_valid,
    output logic              done,
    output logic [2*OP_W-1:0] product
);
    import bsm_pkg::*;

    localparam int BASE_LEN   = ((1 << OP_W) - 1) * ((1 << OP_W) - 1);
    localparam int REP_LEN    = BASE_LEN * REP;
    localparam int STREAM_LEN = REP_LEN + PAD_LEN;
    localparam int POS_W      = $clog2(STREAM_LEN);
    localparam int Q_W        = 2 * OP_W;
    localparam int CNT_W      = $clog2(STREAM_LEN * (REP + 1) + 1);
    localparam int N_COPY     = 3;

    bsm_phase_t       phase;
    logic [POS_W-1:0] pos;
    logic [OP_W-1:0]  a_q;
    logic [OP_W-1:0]  b_q;
    logic             gen_bit;
    logic             run;
    logic             accept;
    logic [Q_W-1:0]   quot [N_COPY];
    logic [Q_W-1:0]   voted;

    assign run          = (phase == PH_RUN);
    assign accept       = (phase == PH_IDLE) && start;
    assign stream_valid = run;
    assign stream_out   = run & (gen_bit ^ flip_in);

    // Sequencer: capture operands, walk the stream, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pos     <= '0;
            a_q     <= '0;
            b_q     <= '0;
            done    <= 1'b0;
            product <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    a_q   <= op_a;
                    b_q   <= op_b;
                    pos   <= '0;
                    phase <= PH_RUN;
                end
                PH_RUN: begin
                    if (pos == POS_W'(STREAM_LEN - 1)) phase <= PH_FIN;
                    else                               pos   <= pos + 1'b1;
                end
                PH_FIN: begin
                    product <= voted;
                    done    <= 1'b1;
                    phase   <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    bsm_stream_gen #(
        .OP_W(OP_W), .REP(REP), .PAD_LEN(PAD_LEN), .PAD_PAT(PAD_PAT), .POS_W(POS_W)
    ) u_gen (
        .a(a_q), .b(b_q), .pos(pos), .bit_o(gen_bit)
    );

    for (genvar k = 0; k < N_COPY; k++) begin : g_copy
        bsm_ones_counter #(.CNT_W(CNT_W), .Q_W(Q_W), .REP(REP)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(accept), .en(run),
            .bit_in(stream_out), .upset(upset_in[k]), .quot(quot[k])
        );
    end

    bsm_voter #(.W(Q_W)) u_vote (
        .v0(quot[0]), .v1(quot[1]), .v2(quot[2]), .v(voted)
    );
endmodule

// File: rtl/bsm_mult_chk.sv
// Checker for bsm_mult, attached with bind. It observes ports and a few
// internal registers (stream position, captured operands, copy results).
module bsm_mult_chk #(
    parameter int OP_W       = 3,
    parameter int REP        = 8,
    parameter int POS_W      = 9,
    parameter int Q_W        = 6,
    parameter int REP_LEN    = 392,
    parameter int STREAM_LEN = 399
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stream_valid,
    input logic             stream_out,
    input logic             flip_in,
    input logic             done,
    input logic [Q_W-1:0]   product,
    input logic [POS_W-1:0] pos,
    input logic [OP_W-1:0]  a_q,
    input logic [OP_W-1:0]  b_q,
    input logic [Q_W-1:0]   q0,
    input logic [Q_W-1:0]   q1
);
    assert_pos_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stream_valid |-> (32'(pos) < STREAM_LEN));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_follows_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_valid) |=> (done && !stream_valid));

    assert_replica_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_valid && $past(stream_valid) && (32'(pos) < REP_LEN) &&
         ((32'(pos) % REP) != 0) && !flip_in && !$past(flip_in))
        |-> (stream_out == $past(stream_out)));

    assert_ops_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_valid && $past(stream_valid)) |-> ($stable(a_q) && $stable(b_q)));

    assert_vote_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (q0 == q1)) |-> (product == q0));

    assert_product_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
endmodule

bind bsm_mult bsm_mult_chk #(
    .OP_W(OP_W), .REP(REP), .POS_W(POS_W), .Q_W(Q_W),
    .REP_LEN(REP_LEN), .STREAM_LEN(STREAM_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stream_valid(stream_valid), .stream_out(stream_out),
    .flip_in(flip_in), .done(done), .product(product), .pos(pos),
    .a_q(a_q), .b_q(b_q), .q0(quot[0]), .q1(quot[1])
);

// File: tb/test_bsm_mult.sv
// Scoreboard bench for bsm_mult. A driver task queues the expected results,
// and a monitor checks each run when done pulses.
module test_bsm_mult;
    localparam int SLEN = 399;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op_a = '0;
    logic [2:0] op_b = '0;
    logic       flip_in = 1'b0;
    logic [2:0] upset_in = '0;
    logic       stream_out;
    logic       stream_valid;
    logic       done;
    logic [5:0] product;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int    exp_prod;
        int    exp_ones;   // -1: not checked
        bit    shape;      // check layout (no flips)
        logic  first_bit;
        string req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bsm_mult i_bsm_mult (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .flip_in(flip_in), .upset_in(upset_in), .stream_out(stream_out),
        .stream_valid(stream_valid), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: push expectation, start, apply faults by stream position.
    task automatic run_op(input int a, input int b, input int nflip,
                          input logic [2:0] umask, input int ucyc,
                          input int glitch_k, input int exp_prod,
                          input int exp_ones, input string req);
        item_t it;
        it.exp_prod  = exp_prod;
        it.exp_ones  = exp_ones;
        it.shape     = (nflip == 0);
        it.first_bit = a[0] & b[0];
        it.req       = req;
        sb_q.push_back(it);
        op_a  = 3'(a);
        op_b  = 3'(b);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < SLEN; k++) begin
            flip_in  = (k < nflip);
            upset_in = (k < ucyc) ? umask : 3'b000;
            start    = (k == glitch_k);
            if (k == glitch_k) begin op_a = 3'd2; op_b = 3'd2; end
            @(posedge clk); @(negedge clk);
        end
        flip_in  = 1'b0;
        upset_in = '0;
        start    = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Monitor: measure the stream, compare on done.
    initial begin
        int         len = 0;
        int         ones = 0;
        logic [7:0] first8 = '0;
        logic [6:0] tail = '0;
        item_t      it;
        forever begin
            @(negedge clk);
            if (rst_n && stream_valid) begin
                len++;
                ones += int'(stream_out);
                if (len <= 8) first8 = {first8[6:0], stream_out};
                tail = {tail[5:0], stream_out};
            end
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(int'(product) == it.exp_prod, it.req, int'(product), it.exp_prod);
                    check(len == SLEN, "R2", len, SLEN);
                    if (it.exp_ones >= 0)
                        check(ones == it.exp_ones, "R3", ones, it.exp_ones);
                    if (it.shape) begin
                        check(tail == 7'b1111000, "R4", int'(tail), int'(7'b1111000));
                        check(first8 == {8{it.first_bit}}, "R4", int'(first8),
                              int'({8{it.first_bit}}));
                    end
                end
                len = 0; ones = 0; first8 = '0; tail = '0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is held
        check(done == 1'b0 && stream_valid == 1'b0 && stream_out == 1'b0, "R1",
              int'({done, stream_valid, stream_out}), 0);
        check(product == 6'd0, "R1", int'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && stream_valid == 1'b0, "R1", int'({done, stream_valid}), 0);

        // R5, R3, R4: all operand pairs, fault free
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                run_op(a, b, 0, 3'b000, 0, -1, a * b, 8 * a * b + 4, "R5");

        // R6: margin on the ones count
        run_op(7, 7, 4, 3'b000, 0, -1, 49, 396 - 4, "R6");
        run_op(7, 7, 5, 3'b000, 0, -1, 48, 396 - 5, "R6");
        run_op(0, 0, 3, 3'b000, 0, -1, 0, 4 + 3, "R6");
        run_op(0, 0, 4, 3'b000, 0, -1, 1, 4 + 4, "R6");

        // R7: a start during the run is ignored
        run_op(6, 5, 0, 3'b000, 0, 100, 30, 244, "R7");

        // R8: one copy upset is outvoted, two copies are not
        run_op(5, 3, 0, 3'b001, 5, -1, 15, 124, "R8");
        run_op(5, 3, 0, 3'b101, 2, -1, 17, 124, "R8");

        // R9: saturation at 63
        run_op(7, 7, 0, 3'b011, SLEN, -1, 63, 396, "R9");

        repeat (3) @(negedge clk);
        // R5: product holds after the last pulse
        check(product == 6'd63 && done == 1'b0, "R5", int'(product), 63);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule